// File: doc/BRIEF.md
# Processor-Side Vectored Interrupt Entry

This block sits on the processor side of a vectored interrupt link. It watches an active-low normal-interrupt line and an active-low fast-interrupt line coming from an interrupt controller. When the normal line is seen low while the core has interrupts enabled, it first spends one cycle deciding whether a fast interrupt is pending. A fast interrupt wins and is reported as a one-cycle pulse without any acknowledge. Otherwise the block raises an acknowledge to the controller. It then waits for the controller's address-valid strobe and captures the 30-bit vector on the first cycle the strobe is seen high. The captured vector is widened with two zero bits into a word-aligned 32-bit branch target and handed to the core's entry logic as a one-cycle ready pulse.

The acknowledge is dropped in the same cycle as the capture. The controller then keeps address-valid high until it has updated its request line. For that reason the block does not look at the normal interrupt line again until it has sampled address-valid low, so a stale low level is never read as a new request. The two request lines and address-valid cross from the controller through a parameterised synchronizer. The enable input only gates the start of a new entry; a handshake that has begun always runs to completion.

Top module: `irq_vector_taker`

## Requirements
- R1: While reset is asserted and until the first entry, `irq_ack`, `vec_ready` and `fiq_take` are 0 and `vec_target` is all zeros.
- R2: With `irq_en` high and `fiq_n` high, `irq_n` held low causes `irq_ack` to rise on the (SYNC_STAGES+2)-th rising edge after the first edge that samples `irq_n` low.
- R3: If the synchronized `fiq_n` is low while the block is idle or in its decision cycle, `fiq_take` pulses high for one cycle and `irq_ack` is not raised for that entry. Fast interrupts win over normal interrupts seen on the same edge.
- R4: On the first edge at which the synchronized `vec_valid` is high while `irq_ack` is high, the block drops `irq_ack`. In the next cycle it holds `vec_ready` high for exactly one cycle, with `vec_target` equal to `{vec_addr, 2'b00}` as sampled on that edge.
- R5: After a capture, `irq_n` has no effect until the synchronized `vec_valid` has been sampled low. No new `irq_ack` rises while the controller still holds `vec_valid` high.
- R6: While `irq_en` is low, a low `irq_n` starts no entry and `irq_ack` stays 0.
- R7: Dropping `irq_en` after an entry has started does not abort it: the acknowledge and capture proceed as in R4.
- R8: A fast interrupt held low gives exactly one `fiq_take` pulse. A new pulse requires the synchronized `fiq_n` to return high first.
- R9: Once raised, `irq_ack` stays high until the synchronized `vec_valid` is seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_n | input | 1 | Active-low normal interrupt request from the controller |
| fiq_n | input | 1 | Active-low fast interrupt request from the controller |
| irq_en | input | 1 | Core's normal-interrupt enable (1 = entries allowed) |
| vec_addr | input | ADDR_W (30) | Vector address bus from the controller, word index |
| vec_valid | input | 1 | Controller strobe: vector address is stable |
| irq_ack | output | 1 | Acknowledge to the controller that a normal interrupt is being taken |
| fiq_take | output | 1 | One-cycle pulse: fast interrupt entry chosen |
| vec_ready | output | 1 | One-cycle pulse: `vec_target` holds a fresh branch target |
| vec_target | output | ADDR_W+2 (32) | Word-aligned branch target, `{vec_addr, 2'b00}` |

## Verification
On every cycle the assertions check the following. A fast-interrupt pulse never coincides with the acknowledge. Neither the ready pulse nor the fast pulse lasts longer than one cycle. The acknowledge holds until valid is seen and falls right after it. Every ready target is word-aligned. The acknowledge never rises while valid was still high or without the enable having been high at the decision point. Other properties can only be shown by the bench's scenarios. These are the exact entry latency through the synchronizer, the masking of the request line during a long valid hold, the completion of a handshake after the enable drops, and a single fast pulse for a held request. The bench checks them against a behavioural model clock by clock.

// File: rtl/ivt_pkg.sv
package ivt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_DECIDE   = 3'd1,
    ST_ACK      = 3'd2,
    ST_DRAIN    = 3'd3,
    ST_FIQ_HOLD = 3'd4
  } entry_state_t;

  localparam int unsigned ALIGN_BITS = 2;

endpackage

// File: rtl/ivt_reset_sync.sv
module ivt_reset_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/ivt_sampler.sv
module ivt_sampler #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      logic [WIDTH-1:0] stage_d;
      if (gi == 0) begin : g_first
        assign stage_d = d;
      end else begin : g_rest
        assign stage_d = stage_q[gi-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[gi] <= RST_VAL;
        else        stage_q[gi] <= stage_d;
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/ivt_entry_fsm.sv
module ivt_entry_fsm
  import ivt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic irq_req_i,
  input  logic fiq_req_i,
  input  logic vld_i,
  input  logic irq_en_i,
  output logic irq_ack_o,
  output logic fiq_take_o,
  output logic capture_o
);
  entry_state_t state_q, state_d;
  logic         ack_q, ack_d;
  logic         fiq_q, fiq_d;

  always_comb begin
    state_d   = state_q;
    fiq_d     = 1'b0;
    capture_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (fiq_req_i) begin
          state_d = ST_FIQ_HOLD;
          fiq_d   = 1'b1;
        end else if (irq_req_i && irq_en_i) begin
          state_d = ST_DECIDE;
        end
      end
      ST_DECIDE: begin
        if (fiq_req_i) begin
          state_d = ST_FIQ_HOLD;
          fiq_d   = 1'b1;
        end else begin
          state_d = ST_ACK;
        end
      end
      ST_ACK: begin
        if (vld_i) begin
          state_d   = ST_DRAIN;
          capture_o = 1'b1;
        end
      end
      ST_DRAIN: begin
        if (!vld_i) state_d = ST_IDLE;
      end
      ST_FIQ_HOLD: begin
        if (!fiq_req_i) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
    ack_d = (state_d == ST_ACK);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ack_q   <= 1'b0;
      fiq_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      ack_q   <= ack_d;
      fiq_q   <= fiq_d;
    end
  end

  assign irq_ack_o  = ack_q;
  assign fiq_take_o = fiq_q;

  // R3: a fast entry never coincides with a normal acknowledge
  a_r3_fiq_excludes_ack: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_take_o |-> !irq_ack_o);
  // R8: fast entry reported as a single pulse
  a_r8_fiq_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_take_o |=> !fiq_take_o);
  // R9: acknowledge held until valid is seen
  a_r9_ack_held: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack_o && !vld_i) |=> irq_ack_o);
  // R4: acknowledge released right after valid is seen
  a_r4_ack_release: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack_o && vld_i) |=> !irq_ack_o);
endmodule

// File: rtl/ivt_vector_capture.sv
module ivt_vector_capture
  import ivt_pkg::*;
#(
  parameter int unsigned ADDR_W = 30,
  localparam int unsigned TGT_W = ADDR_W + ALIGN_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture_i,
  input  logic [ADDR_W-1:0] vec_addr_i,
  output logic              ready_o,
  output logic [TGT_W-1:0]  target_o
);
  logic             ready_q;
  logic [TGT_W-1:0] target_q, target_d;
  logic             target_en;

  assign target_en = capture_i;
  assign target_d  = {vec_addr_i, {ALIGN_BITS{1'b0}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= capture_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         target_q <= '0;
    else if (target_en) target_q <= target_d;
  end

  assign ready_o  = ready_q;
  assign target_o = target_q;

  // R4: ready is a one-cycle pulse
  a_r4_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |=> !ready_o);
  // R4: every delivered target is word-aligned
  a_r4_target_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |-> (target_o[ALIGN_BITS-1:0] == '0));
endmodule

// File: rtl/irq_vector_taker.sv
module irq_vector_taker
  import ivt_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned ADDR_W      = 30,
  localparam int unsigned TGT_W      = ADDR_W + ALIGN_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq_n,
  input  logic              fiq_n,
  input  logic              irq_en,
  input  logic [ADDR_W-1:0] vec_addr,
  input  logic              vec_valid,
  output logic              irq_ack,
  output logic              fiq_take,
  output logic              vec_ready,
  output logic [TGT_W-1:0]  vec_target
);
  logic       rst_sync_n;
  logic [2:0] raw_lines, sync_lines;
  logic       irq_req, fiq_req, vld_s, capture;

  ivt_reset_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  assign raw_lines = {irq_n, fiq_n, vec_valid};

  ivt_sampler #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)) u_sync (
    .clk(clk), .rst_n(rst_sync_n), .d(raw_lines), .q(sync_lines));

  assign irq_req = ~sync_lines[2];
  assign fiq_req = ~sync_lines[1];
  assign vld_s   =  sync_lines[0];

  ivt_entry_fsm u_fsm (
    .clk(clk), .rst_n(rst_sync_n),
    .irq_req_i(irq_req), .fiq_req_i(fiq_req), .vld_i(vld_s), .irq_en_i(irq_en),
    .irq_ack_o(irq_ack), .fiq_take_o(fiq_take), .capture_o(capture));

  ivt_vector_capture #(.ADDR_W(ADDR_W)) u_cap (
    .clk(clk), .rst_n(rst_sync_n), .capture_i(capture), .vec_addr_i(vec_addr),
    .ready_o(vec_ready), .target_o(vec_target));

  // R5: no new acknowledge while the controller still shows valid
  a_r5_no_rearm_under_valid: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(irq_ack) |-> !$past(vld_s));
  // R6: an acknowledge needs the enable at the start of the entry
  a_r6_enable_gates_entry: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(irq_ack) |-> $past(irq_en, 2));
  // R4: ready follows the acknowledge cycle
  a_r4_ready_after_ack: assert property (@(posedge clk) disable iff (!rst_sync_n)
    vec_ready |-> $past(irq_ack));
endmodule

// File: tb/irq_vector_taker_test.sv
`timescale 1ns/1ps
module irq_vector_taker_test;
  localparam int CLK_PERIOD = 10;
  localparam int SYNC = 2;

  logic        clk = 1'b0;
  logic        rst_n, irq_n, fiq_n, irq_en, vec_valid;
  logic [29:0] vec_addr, next_addr;
  logic        irq_ack, fiq_take, vec_ready;
  logic [31:0] vec_target;

  int checks = 0, errors = 0, cycles = 0;
  int ack_lat = 1, rel_lat = 1, rsp_cnt = 0;
  int ack_rises = 0, fiq_pulses = 0, ready_pulses = 0, rearm_in_valid = 0;
  logic ack_prev = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_vector_taker uut (
    .clk(clk), .rst_n(rst_n), .irq_n(irq_n), .fiq_n(fiq_n), .irq_en(irq_en),
    .vec_addr(vec_addr), .vec_valid(vec_valid), .irq_ack(irq_ack),
    .fiq_take(fiq_take), .vec_ready(vec_ready), .vec_target(vec_target));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  // behavioural reference: input delay lines plus an entry phase counter
  logic [SYNC-1:0] m_irq_dl, m_fiq_dl, m_vld_dl;
  int          m_phase;
  logic        m_ack, m_fiq, m_ready;
  logic [31:0] m_target;
  wire m_irq_act = !m_irq_dl[SYNC-1];
  wire m_fiq_act = !m_fiq_dl[SYNC-1];
  wire m_vld     =  m_vld_dl[SYNC-1];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_irq_dl <= '1; m_fiq_dl <= '1; m_vld_dl <= '0;
      m_phase <= 0; m_ack <= 0; m_fiq <= 0; m_ready <= 0; m_target <= 0;
    end else begin
      m_irq_dl <= {m_irq_dl[SYNC-2:0], irq_n};
      m_fiq_dl <= {m_fiq_dl[SYNC-2:0], fiq_n};
      m_vld_dl <= {m_vld_dl[SYNC-2:0], vec_valid};
      m_fiq <= 0; m_ready <= 0;
      case (m_phase)
        0: if (m_fiq_act) begin m_fiq <= 1; m_phase <= 4; end
           else if (m_irq_act && irq_en) m_phase <= 1;
        1: if (m_fiq_act) begin m_fiq <= 1; m_phase <= 4; end
           else begin m_ack <= 1; m_phase <= 2; end
        2: if (m_vld) begin
             m_ack <= 0; m_ready <= 1; m_target <= {vec_addr, 2'b00}; m_phase <= 3;
           end
        3: if (!m_vld) m_phase <= 0;
        default: if (!m_fiq_act) m_phase <= 0;
      endcase
    end
  end

  // per-cycle comparison and event counting, away from the active edge
  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      check("R2 R9 irq_ack", irq_ack, m_ack);
      check("R3 R8 fiq_take", fiq_take, m_fiq);
      check("R4 vec_ready", vec_ready, m_ready);
      check("R4 vec_target", vec_target, m_target);
      if (irq_ack && !ack_prev) begin
        ack_rises++;
        if (vec_valid) rearm_in_valid++;
      end
      if (fiq_take) fiq_pulses++;
      if (vec_ready) ready_pulses++;
      ack_prev = irq_ack;
    end
  end

  // controller responder
  always @(negedge clk) begin
    if (!rst_n) begin
      vec_valid = 0; rsp_cnt = 0;
    end else if (irq_ack && !vec_valid) begin
      if (rsp_cnt >= ack_lat) begin vec_valid = 1; vec_addr = next_addr; rsp_cnt = 0; end
      else rsp_cnt++;
    end else if (!irq_ack && vec_valid) begin
      if (rsp_cnt >= rel_lat) begin vec_valid = 0; rsp_cnt = 0; end
      else rsp_cnt++;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_ready(input string req);
    int t = 0;
    while (!vec_ready && t < 60) begin @(negedge clk); t++; end
    check(req, {31'd0, vec_ready}, 32'd1);
  endtask

  initial begin
    int base, lat;
    rst_n = 0; irq_n = 1; fiq_n = 1; irq_en = 1; vec_addr = '0; next_addr = 30'h0;
    idle(3);
    // R1 reset values
    check("R1 ack", irq_ack, 0); check("R1 ready", vec_ready, 0);
    check("R1 fiq", fiq_take, 0); check("R1 target", vec_target, 0);
    rst_n = 1; idle(4);
    check("R1 idle ack", irq_ack, 0);

    // R2 entry latency and R4 capture
    next_addr = 30'h2ABC_DEF1;
    irq_n = 0; lat = 0;
    while (!irq_ack && lat < 30) begin @(negedge clk); lat++; end
    check("R2 latency", lat, SYNC + 2);
    wait_ready("R4 ready seen");
    check("R4 target", vec_target, {30'h2ABC_DEF1, 2'b00});
    irq_n = 1; idle(10);

    // R5 request held low through a long valid hold
    rel_lat = 8; next_addr = 30'h0000_0003;
    base = ack_rises; irq_n = 0;
    wait_ready("R5 first ready");
    next_addr = 30'h1000_0000;
    idle(40); irq_n = 1; idle(12);
    check("R5 rearm under valid", rearm_in_valid, 0);
    check("R5 rises bounded", {31'd0, (ack_rises - base) >= 2}, 32'd1);
    rel_lat = 1;

    // R6 masked entry
    irq_en = 0; base = ack_rises; irq_n = 0; idle(20);
    check("R6 masked ack", ack_rises - base, 0);
    // R7 enable dropped mid-handshake
    ack_lat = 6; next_addr = 30'h0155_5555; irq_en = 1;
    while (!irq_ack) @(negedge clk);
    irq_en = 0; irq_n = 1;
    wait_ready("R7 ready despite enable low");
    check("R7 target", vec_target, {30'h0155_5555, 2'b00});
    ack_lat = 1; irq_en = 1; idle(12);

    // R3 simultaneous requests
    base = fiq_pulses; lat = ack_rises;
    irq_n = 0; fiq_n = 0; idle(15);
    check("R3 fiq pulse", fiq_pulses - base, 1);
    check("R3 no ack", ack_rises - lat, 0);
    // R8 held fast request gives one pulse only
    irq_n = 1; idle(15);
    check("R8 single pulse", fiq_pulses - base, 1);
    fiq_n = 1; idle(6);
    // R3 fast request during the decision cycle
    base = fiq_pulses; lat = ack_rises;
    irq_n = 0; @(negedge clk); fiq_n = 0; idle(12);
    check("R3 decide fiq", fiq_pulses - base, 1);
    check("R3 decide no ack", ack_rises - lat, 0);
    irq_n = 1; fiq_n = 1; idle(10);
    check("R8 rearm fiq", {31'd0, fiq_take}, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule